// File: doc/BRIEF.md
# Synchronous Burst SRAM with Byte-Lane Writes

This block is a single-port synchronous memory built from 36-bit words. Each word is split into four 9-bit lanes. The default depth is small (1024 words) so that it elaborates quickly. With `AW` set to 15 it holds 32,768 words. An access begins when either of two address strobes is sampled low at a clock edge. One strobe is processor-side and the other is controller-side. After that, an active-low advance input moves a 2-bit burst counter through the aligned group of four words. The counter runs in either linear or interleaved order, as chosen by a mode pin. While the advance input is held high, the burst waits on its current word.

Reads are flow-through. The word at the registered address comes straight from the array in the cycle after the edge that chose it, with no output register. The bidirectional data bus is modelled as three signals: an input word, an output word and an output enable. The output is driven only when all of the following hold:
- output-enable is low;
- a burst is active;
- the device is not asleep;
- no write has happened since the last strobe or advance.

Writes land on the address that the same edge selects. The global write input gives a full-width write. The byte-write input instead gives a write of only the lanes selected by the per-lane enables.

The memory accepts a command on every clock edge and has no back-pressure. There is no valid/ready handshake: every port is a plain control or data pin that is sampled at each rising edge.

Top module: `sbsram_top`

## Requirements
- R1: With reset low, `dout_en` is 0. After a strobe edge with chip enable low, no write, `oe_n` low and `sleep` low, the next cycle shows `dout_en`=1 and `dout` equal to the stored word at the strobed address.
- R2: With `interleave`=0, each edge with `adv_n` low during an active burst steps the counter by one. The word shown is then at {start[AW-1:2], (start[1:0]+k) mod 4}, where k is the number of steps. After four steps it wraps back to the start word.
- R3: With `interleave`=1, the low two address bits are start[1:0] XOR k, and the upper bits stay fixed.
- R4: An edge with `adv_n` high and no strobe keeps the current address and count.
- R5: A controller strobe (`ctl_strb_n`=0) during a burst loads the new address and resets the count to 0.
- R6: `wr_all_n`=0 at an edge writes all 36 bits of `din`, whatever `byte_wr_n` and `lane_en_n` are.
- R7: With `wr_all_n`=1 and `byte_wr_n`=0, lane i (bits 9i+8..9i) is written only when `lane_en_n[i]`=0. The other lanes keep their contents.
- R8: An edge with no lane selected is a read. This covers `byte_wr_n`=1, and also `byte_wr_n`=0 with `lane_en_n`=4'b1111. Such an edge leaves the array unchanged, and the output drives in the next cycle.
- R9: A processor strobe (`cpu_strb_n`=0) starts the access as a read and ignores the write inputs. When `ce_n`=1, the processor strobe is ignored.
- R10: Any edge with `ce_n`=1 ends the burst. `dout_en` stays 0 after it, and `adv_n` does not resume the burst.
- R11: While `oe_n`=1, `dout_en` is 0 and `dout` is 0. This check is combinational.
- R12: After an edge that writes, `dout_en` is 0 until an edge that has a strobe or an advance and no write.
- R13: While `sleep`=1, `dout_en` is 0. Edges with `sleep` high write nothing and end the burst. After sleep ends, the output stays off until a new strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | AW | Start address sampled on a strobe |
| cpu_strb_n | input | 1 | Processor-side strobe, active low, starts a read |
| ctl_strb_n | input | 1 | Controller-side strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce_n | input | 1 | Chip enable, active low |
| interleave | input | 1 | Burst order: 0 linear, 1 interleaved |
| wr_all_n | input | 1 | Global full-width write, active low |
| byte_wr_n | input | 1 | Byte-write enable, active low |
| lane_en_n | input | 4 | Per-lane write select, active low |
| oe_n | input | 1 | Output enable, active low |
| sleep | input | 1 | Sleep request, active high |
| din | input | 36 | Write data |
| dout | output | 36 | Read data, 0 when not driven |
| dout_en | output | 1 | High when the data bus is driven |

## Verification
A wrong burst count or base register shows up one cycle later as the word from a neighbouring address on `dout`. In the linear sweep this becomes clear within four advance cycles, because the wrap has to return to the start word. A wrong lane mask shows up only when the word is read back. For that reason every lane mask is written over a known background and then re-read. A wrong write-shadow or active flag shows up at once as `dout_en` being wrong in the cycle after a write, a deselect or a sleep edge.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int WORD_W = LANES * LANE_W;

  function automatic logic [1:0] order_bits(input logic [1:0] start,
                                            input logic [1:0] cnt,
                                            input logic       interleave);
    return interleave ? (start ^ cnt) : (start + cnt);
  endfunction
endpackage

// File: rtl/sbsram_burst_seq.sv
module sbsram_burst_seq #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic          clear,
  input  logic [AW-1:0] load_addr,
  input  logic          interleave,
  output logic          active,
  output logic [1:0]    cnt,
  output logic [AW-1:0] cur_addr,
  output logic [AW-1:0] nxt_addr
);
  import sbsram_pkg::*;

  logic [AW-1:0] base_q, base_d;
  logic [1:0]    cnt_q, cnt_d;
  logic          act_q, act_d;

  always_comb begin
    base_d = load ? load_addr : base_q;
    if (load)      cnt_d = 2'd0;
    else if (step) cnt_d = cnt_q + 2'd1;
    else           cnt_d = cnt_q;
    if (clear)     act_d = 1'b0;
    else if (load) act_d = 1'b1;
    else           act_d = act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= 2'd0;
      act_q  <= 1'b0;
    end else begin
      base_q <= base_d;
      cnt_q  <= cnt_d;
      act_q  <= act_d;
    end
  end

  assign active   = act_q;
  assign cnt      = cnt_q;
  assign cur_addr = {base_q[AW-1:2], order_bits(base_q[1:0], cnt_q, interleave)};
  assign nxt_addr = {base_d[AW-1:2], order_bits(base_d[1:0], cnt_d, interleave)};
endmodule

// File: rtl/sbsram_lane_decode.sv
module sbsram_lane_decode
  import sbsram_pkg::*;
(
  input  logic             wr_all_n,
  input  logic             byte_wr_n,
  input  logic [LANES-1:0] lane_en_n,
  output logic [LANES-1:0] mask
);
  always_comb begin
    if (!wr_all_n)       mask = '1;
    else if (!byte_wr_n) mask = ~lane_en_n;
    else                 mask = '0;
  end
endmodule

// File: rtl/sbsram_lane_store.sv
module sbsram_lane_store
  import sbsram_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic              clk,
  input  logic [LANES-1:0]  we,
  input  logic [AW-1:0]     waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [WORD_W-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];
    always_ff @(posedge clk) begin
      if (we[g]) cells[waddr] <= wdata[g*LANE_W +: LANE_W];
    end
    assign rdata[g*LANE_W +: LANE_W] = cells[raddr];
  end
endmodule

// File: rtl/sbsram_out_gate.sv
module sbsram_out_gate
  import sbsram_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrote,
  input  logic              resume,
  input  logic              active,
  input  logic              oe_n,
  input  logic              sleep,
  input  logic [WORD_W-1:0] rdata,
  output logic [WORD_W-1:0] dout,
  output logic              dout_en
);
  logic shadow_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      shadow_q <= 1'b0;
    else if (wrote)  shadow_q <= 1'b1;
    else if (resume) shadow_q <= 1'b0;
  end

  assign dout_en = active & ~shadow_q & ~oe_n & ~sleep;
  assign dout    = dout_en ? rdata : '0;
endmodule

// File: rtl/sbsram_top.sv
module sbsram_top
  import sbsram_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     addr,
  input  logic              cpu_strb_n,
  input  logic              ctl_strb_n,
  input  logic              adv_n,
  input  logic              ce_n,
  input  logic              interleave,
  input  logic              wr_all_n,
  input  logic              byte_wr_n,
  input  logic [LANES-1:0]  lane_en_n,
  input  logic              oe_n,
  input  logic              sleep,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] dout,
  output logic              dout_en
);
  logic             cpu_go, ctl_go, load, clear, step, wr_cycle, wrote;
  logic             active;
  logic [1:0]       burst_cnt;
  logic [AW-1:0]    cur_addr, nxt_addr;
  logic [LANES-1:0] mask, we;
  logic [WORD_W-1:0] rdata;

  assign clear    = sleep | ce_n;
  assign cpu_go   = ~clear & ~cpu_strb_n;
  assign ctl_go   = ~clear & ~ctl_strb_n & cpu_strb_n;
  assign load     = cpu_go | ctl_go;
  assign step     = ~clear & ~load & active & ~adv_n;
  assign wr_cycle = ~clear & ~cpu_go & (ctl_go | active);
  assign we       = mask & {LANES{wr_cycle}};
  assign wrote    = |we;

  sbsram_burst_seq #(.AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step), .clear(clear),
    .load_addr(addr), .interleave(interleave), .active(active),
    .cnt(burst_cnt), .cur_addr(cur_addr), .nxt_addr(nxt_addr)
  );

  sbsram_lane_decode u_dec (
    .wr_all_n(wr_all_n), .byte_wr_n(byte_wr_n), .lane_en_n(lane_en_n), .mask(mask)
  );

  sbsram_lane_store #(.AW(AW)) u_store (
    .clk(clk), .we(we), .waddr(nxt_addr), .wdata(din),
    .raddr(cur_addr), .rdata(rdata)
  );

  sbsram_out_gate u_out (
    .clk(clk), .rst_n(rst_n), .wrote(wrote), .resume(load | step),
    .active(active), .oe_n(oe_n), .sleep(sleep), .rdata(rdata),
    .dout(dout), .dout_en(dout_en)
  );
endmodule

// File: rtl/sbsram_checker.sv
module sbsram_checker #(
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] addr,
  input logic          cpu_strb_n,
  input logic          ctl_strb_n,
  input logic          adv_n,
  input logic          ce_n,
  input logic          wr_all_n,
  input logic          byte_wr_n,
  input logic [3:0]    lane_en_n,
  input logic          oe_n,
  input logic          sleep,
  input logic          dout_en,
  input logic          active,
  input logic [1:0]    burst_cnt,
  input logic [AW-1:0] cur_addr
);
  logic live, any_strobe, lane_req, wr_fire;
  assign live       = ~ce_n & ~sleep;
  assign any_strobe = live & (~cpu_strb_n | ~ctl_strb_n);
  assign lane_req   = ~wr_all_n | (~byte_wr_n & (lane_en_n != 4'hF));
  assign wr_fire    = live & cpu_strb_n & (~ctl_strb_n | active) & lane_req;

  // R11
  oe_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dout_en);
  // R13
  sleep_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> !dout_en);
  // R10
  desel_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n && !sleep) |=> !active);
  // R4
  hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live && active && !any_strobe && adv_n) |=> $stable(cur_addr));
  // R2
  step_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live && active && !any_strobe && !adv_n) |=> burst_cnt == $past(burst_cnt) + 2'd1);
  // R5
  load_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_strobe |=> (cur_addr == $past(addr) && burst_cnt == 2'd0));
  // R12
  wr_shadow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> !dout_en);
endmodule

bind sbsram_top sbsram_checker #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .cpu_strb_n(cpu_strb_n),
  .ctl_strb_n(ctl_strb_n), .adv_n(adv_n), .ce_n(ce_n), .wr_all_n(wr_all_n),
  .byte_wr_n(byte_wr_n), .lane_en_n(lane_en_n), .oe_n(oe_n), .sleep(sleep),
  .dout_en(dout_en), .active(active), .burst_cnt(burst_cnt), .cur_addr(cur_addr)
);

// File: tb/tb_sbsram_top.sv
`timescale 1ns/1ps
module tb_sbsram_top;
  localparam int AW = 4;
  localparam int N  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic          cpu_strb_n, ctl_strb_n, adv_n, ce_n, interleave;
  logic          wr_all_n, byte_wr_n, oe_n, sleep;
  logic [3:0]    lane_en_n;
  logic [35:0]   din, dout;
  logic          dout_en;

  logic [35:0]   exp_mem [N];
  int            total = 0;
  int            fails = 0;

  always #4 clk = ~clk;

  sbsram_top #(.AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .cpu_strb_n(cpu_strb_n),
    .ctl_strb_n(ctl_strb_n), .adv_n(adv_n), .ce_n(ce_n), .interleave(interleave),
    .wr_all_n(wr_all_n), .byte_wr_n(byte_wr_n), .lane_en_n(lane_en_n),
    .oe_n(oe_n), .sleep(sleep), .din(din), .dout(dout), .dout_en(dout_en)
  );

  function automatic logic [35:0] pat(input int a);
    return (36'(a) * 36'h0_0102_0305) ^ 36'h5_A5C3_9E1F;
  endfunction

  task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    addr = '0; cpu_strb_n = 1'b1; ctl_strb_n = 1'b1; adv_n = 1'b1; ce_n = 1'b0;
    wr_all_n = 1'b1; byte_wr_n = 1'b1; lane_en_n = 4'hF; oe_n = 1'b0;
    sleep = 1'b0; din = '0;
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic ctl_write_all(input int a, input logic [35:0] d);
    idle(); addr = AW'(a); ctl_strb_n = 1'b0; wr_all_n = 1'b0; din = d;
    tick();
    exp_mem[a] = d;
  endtask

  task automatic ctl_read(input int a, input string req);
    idle(); addr = AW'(a); ctl_strb_n = 1'b0;
    tick();
    chk(req, {35'd0, dout_en}, 36'd1);
    chk(req, dout, exp_mem[a]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    idle(); interleave = 1'b0; rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    // R1 reset state
    chk("R1 reset", {35'd0, dout_en}, 36'd0);
    rst_n = 1'b1;
    tick();

    // R6 fill every word with a global write, output shadowed afterwards (R12)
    for (int a = 0; a < N; a++) begin
      ctl_write_all(a, pat(a));
      chk("R12 after fill write", {35'd0, dout_en}, 36'd0);
    end
    // R1 flow-through read of every word
    for (int a = 0; a < N; a++) ctl_read(a, "R1 read back");

    // R2 linear and R3 interleaved sweeps over every start address
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < N; s++) begin
        idle(); interleave = m[0]; addr = AW'(s); cpu_strb_n = 1'b0;
        tick();
        chk(m ? "R3 start" : "R2 start", dout, exp_mem[s]);
        for (int k = 1; k <= 4; k++) begin
          int ea;
          idle(); interleave = m[0]; adv_n = 1'b0;
          tick();
          ea = m ? ((s & ~3) | ((s ^ k) & 3)) : ((s & ~3) | ((s + k) & 3));
          chk(m ? "R3 step" : "R2 step", dout, exp_mem[ea]);
        end
      end
    end
    interleave = 1'b0;

    // R4 suspend holds the address
    idle(); addr = 4'd5; cpu_strb_n = 1'b0; tick();
    idle(); adv_n = 1'b0; tick();
    idle(); tick(); tick();
    chk("R4 hold", dout, exp_mem[6]);
    idle(); adv_n = 1'b0; tick();
    chk("R4 resume", dout, exp_mem[7]);

    // R5 controller strobe restarts mid-burst
    idle(); addr = 4'd10; ctl_strb_n = 1'b0; tick();
    chk("R5 restart", dout, exp_mem[10]);
    idle(); adv_n = 1'b0; tick();
    chk("R5 count from zero", dout, exp_mem[11]);

    // R6 global write overrides lane enables
    idle(); addr = 4'd3; ctl_strb_n = 1'b0; wr_all_n = 1'b0; byte_wr_n = 1'b0;
    lane_en_n = 4'hF; din = 36'h9_1234_5678; tick();
    exp_mem[3] = 36'h9_1234_5678;
    ctl_read(3, "R6 global write");

    // R7 every lane mask over a known background
    for (int m = 0; m < 16; m++) begin
      logic [35:0] bg, nw, ex;
      bg = pat(100 + m);
      nw = ~bg ^ 36'h1_0F0F_0F0F;
      ctl_write_all(9, bg);
      idle(); addr = 4'd9; ctl_strb_n = 1'b0; byte_wr_n = 1'b0;
      lane_en_n = ~4'(m); din = nw; tick();
      for (int l = 0; l < 4; l++)
        ex[l*9 +: 9] = m[l] ? nw[l*9 +: 9] : bg[l*9 +: 9];
      exp_mem[9] = ex;
      ctl_read(9, "R7 lane mask");
    end

    // R8 byte-write with no lane selected is a read
    idle(); addr = 4'd9; ctl_strb_n = 1'b0; byte_wr_n = 1'b0; lane_en_n = 4'hF;
    din = 36'd0; tick();
    chk("R8 drives", {35'd0, dout_en}, 36'd1);
    chk("R8 unchanged", dout, exp_mem[9]);

    // R9 processor strobe ignores writes
    idle(); addr = 4'd4; cpu_strb_n = 1'b0; wr_all_n = 1'b0; din = 36'd0; tick();
    chk("R9 no write", dout, exp_mem[4]);
    // R9 processor strobe ignored with chip disabled; R10 deselect ends burst
    idle(); addr = 4'd2; cpu_strb_n = 1'b0; ce_n = 1'b1; tick();
    chk("R9 ignored", {35'd0, dout_en}, 36'd0);
    idle(); adv_n = 1'b0; tick();
    chk("R10 no resume", {35'd0, dout_en}, 36'd0);

    // R11 output enable
    idle(); addr = 4'd1; ctl_strb_n = 1'b0; oe_n = 1'b1; tick();
    chk("R11 off en", {35'd0, dout_en}, 36'd0);
    chk("R11 off data", dout, 36'd0);
    oe_n = 1'b0; #1;
    chk("R11 on", dout, exp_mem[1]);

    // R12 shadow after writes until a non-writing strobe or advance
    ctl_write_all(12, 36'h0_AAAA_5555);
    chk("R12 write", {35'd0, dout_en}, 36'd0);
    idle(); tick();
    chk("R12 idle", {35'd0, dout_en}, 36'd0);
    idle(); adv_n = 1'b0; wr_all_n = 1'b0; din = 36'h7_0000_00FF; tick();
    exp_mem[13] = 36'h7_0000_00FF;
    chk("R12 adv write", {35'd0, dout_en}, 36'd0);
    idle(); adv_n = 1'b0; tick();
    chk("R12 released", dout, exp_mem[14]);
    ctl_read(13, "R12 adv write data");

    // R13 sleep
    ctl_read(0, "R13 pre");
    idle(); sleep = 1'b1; #1;
    chk("R13 during", {35'd0, dout_en}, 36'd0);
    addr = 4'd0; ctl_strb_n = 1'b0; wr_all_n = 1'b0; din = 36'hF_FFFF_FFFF; tick();
    idle(); tick();
    chk("R13 after", {35'd0, dout_en}, 36'd0);
    idle(); adv_n = 1'b0; tick();
    chk("R13 adv", {35'd0, dout_en}, 36'd0);
    ctl_read(0, "R13 no write");

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule